// File: doc/BRIEF.md
# Block Floating-Point Growth Detector

This block serves FFT butterfly passes that use block floating-point scaling. It holds a 20-bit auxiliary complex accumulator that sums the already shifted 16-bit real and imaginary samples. Under an accumulate/dump control, it either keeps adding to a running total or moves the finished total into a pair of holding registers and starts a new sum.

A growth detector looks at a four-bit window in each of four registers: the two auxiliary holding registers and the two multiplier-path holding registers. The multiplier-path windows arrive as inputs. From each window it forms a two-bit growth code and reports the largest of the four codes on a registered output. When peak mode is on, the output instead keeps the largest code seen since the mode was enabled. The pass controller uses this to pick the shift for the next pass.

Top module: `bfp_growth_detector`

## Requirements
- R1: Asynchronous active-low reset clears the growth output to 00 and both holding registers to zero.
- R2: While the registered accumulate control is high, each clock adds the sign-extended real and imaginary samples to the running totals, wrapping modulo 2^20.
- R3: While the registered accumulate control is low, a clock copies the running totals into the holding registers and restarts each total with the current sample. While it is high, the holding registers keep their value.
- R4: The accumulate and peak controls are sampled by the clock and act on the following clock edge.
- R5: Each examined window is four bits. The auxiliary windows are bits 18:15 and the multiplier windows are bits 33:30, given as 4-bit inputs. The top bit of the window is the reference. The code is 3 if the next bit differs from the reference, else 2 if the bit below that differs, else 1 if the lowest bit differs, else 0.
- R6: The current growth value is the largest of the four window codes.
- R7: With peak mode off, each clock loads the output register with the current growth value computed from the holding registers and the multiplier windows as they stood before that edge.
- R8: With peak mode on, each clock loads the output with the larger of its present value and the current growth value, so the output never decreases.
- R9: When peak mode turns off, the output returns to tracking the current growth value on the next clock.
- R10: The peak kept in peak mode includes the value that was present when the mode was enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_ctl | input | 1 | 1 = accumulate, 0 = dump and restart (registered) |
| peak_ctl | input | 1 | 1 = peak-hold mode (registered) |
| re_in | input | 16 | Shifted real sample, two's complement |
| im_in | input | 16 | Shifted imaginary sample, two's complement |
| mul_re_fld | input | 4 | Bits 33:30 of the multiplier real holding register |
| mul_im_fld | input | 4 | Bits 33:30 of the multiplier imaginary holding register |
| hold_re | output | 20 | Auxiliary real holding register |
| hold_im | output | 20 | Auxiliary imaginary holding register |
| growth | output | 2 | Growth code, 0 to 3 bits |

## Verification
On every cycle, the assertions check three things. The holding registers stay frozen while accumulation is on. With peak mode off, the output follows the maximum window code of the previous cycle. With peak mode on, the output never falls below either its own earlier value or the code of that cycle. Other behaviour only shows in the bench scenarios: the code of each single window pattern, wrap-around of long sums, the one-cycle delay of both controls, and the value held at the moment peak mode starts.

// File: rtl/bfp_growth_detector.sv
module bfp_growth_detector #(
  parameter int IN_W    = 16,
  parameter int ACC_W   = 20,
  parameter int FLD_LSB = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ctl,
  input  logic             peak_ctl,
  input  logic [IN_W-1:0]  re_in,
  input  logic [IN_W-1:0]  im_in,
  input  logic [3:0]       mul_re_fld,
  input  logic [3:0]       mul_im_fld,
  output logic [ACC_W-1:0] hold_re,
  output logic [ACC_W-1:0] hold_im,
  output logic [1:0]       growth
);
  localparam int EXT_W = ACC_W - IN_W;

  function automatic logic [1:0] fld_code(input logic [3:0] f);
    logic [1:0] c;
    if (f[2] != f[3])      c = 2'd3;
    else if (f[1] != f[3]) c = 2'd2;
    else if (f[0] != f[3]) c = 2'd1;
    else                   c = 2'd0;
    return c;
  endfunction

  function automatic logic [1:0] max2(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic             acc_q, peak_q;
  logic [ACC_W-1:0] sum_re, sum_im;
  logic [ACC_W-1:0] ext_re, ext_im;
  logic [1:0]       cur;

  assign ext_re = {{EXT_W{re_in[IN_W-1]}}, re_in};
  assign ext_im = {{EXT_W{im_in[IN_W-1]}}, im_in};

  assign cur = max2(max2(fld_code(hold_re[FLD_LSB+3:FLD_LSB]), fld_code(hold_im[FLD_LSB+3:FLD_LSB])),
                    max2(fld_code(mul_re_fld), fld_code(mul_im_fld)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      peak_q <= 1'b0;
    end else begin
      acc_q  <= acc_ctl;
      peak_q <= peak_ctl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_re  <= '0;
      sum_im  <= '0;
      hold_re <= '0;
      hold_im <= '0;
    end else if (acc_q) begin
      sum_re <= sum_re + ext_re;
      sum_im <= sum_im + ext_im;
    end else begin
      hold_re <= sum_re;
      hold_im <= sum_im;
      sum_re  <= ext_re;
      sum_im  <= ext_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      growth <= 2'd0;
    else if (peak_q) growth <= max2(growth, cur);
    else             growth <= cur;
  end
endmodule

module bfp_growth_detector_chk #(
  parameter int ACC_W   = 20,
  parameter int FLD_LSB = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_q,
  input logic             peak_q,
  input logic [ACC_W-1:0] hold_re,
  input logic [ACC_W-1:0] hold_im,
  input logic [3:0]       mul_re_fld,
  input logic [3:0]       mul_im_fld,
  input logic [1:0]       growth
);
  function automatic int unsigned win(input logic [3:0] f);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 3; i++)
      if (n == 0 && f[2-i] != f[3]) n = 3 - i;
    return n;
  endfunction

  int unsigned ref_cur;
  always_comb begin
    ref_cur = win(hold_re[FLD_LSB+3:FLD_LSB]);
    if (win(hold_im[FLD_LSB+3:FLD_LSB]) > ref_cur) ref_cur = win(hold_im[FLD_LSB+3:FLD_LSB]);
    if (win(mul_re_fld) > ref_cur) ref_cur = win(mul_re_fld);
    if (win(mul_im_fld) > ref_cur) ref_cur = win(mul_im_fld);
  end

  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> ($stable(hold_re) && $stable(hold_im)));

  p_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_q |=> (32'(growth) == $past(ref_cur)));

  p_peak_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    peak_q |=> (growth >= $past(growth)));

  p_peak_covers_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_q |=> (32'(growth) >= $past(ref_cur)));
endmodule

bind bfp_growth_detector bfp_growth_detector_chk #(.ACC_W(ACC_W), .FLD_LSB(FLD_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_q(acc_q), .peak_q(peak_q),
  .hold_re(hold_re), .hold_im(hold_im),
  .mul_re_fld(mul_re_fld), .mul_im_fld(mul_im_fld), .growth(growth));

// File: tb/bfp_growth_detector_test.sv
module bfp_growth_detector_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_ctl = 1'b0, peak_ctl = 1'b0;
  logic [15:0] re_in = '0, im_in = '0;
  logic [3:0]  mul_re_fld = '0, mul_im_fld = '0;
  logic [19:0] hold_re, hold_im;
  logic [1:0]  growth;

  int total = 0, bad = 0;
  bit done = 1'b0;

  bfp_growth_detector uut (
    .clk(clk), .rst_n(rst_n), .acc_ctl(acc_ctl), .peak_ctl(peak_ctl),
    .re_in(re_in), .im_in(im_in), .mul_re_fld(mul_re_fld), .mul_im_fld(mul_im_fld),
    .hold_re(hold_re), .hold_im(hold_im), .growth(growth));

  always #(CLK_P/2) clk = ~clk;

  // {mul_re_fld, mul_im_fld, expected code}
  localparam logic [9:0] VEC [12] = '{
    {4'b0000, 4'b0000, 2'd0}, {4'b1111, 4'b0000, 2'd0},
    {4'b0001, 4'b0000, 2'd1}, {4'b1110, 4'b0000, 2'd1},
    {4'b0010, 4'b0000, 2'd2}, {4'b1101, 4'b0000, 2'd2},
    {4'b0100, 4'b0000, 2'd3}, {4'b1011, 4'b0000, 2'd3},
    {4'b0001, 4'b0011, 2'd2}, {4'b1110, 4'b1000, 2'd3},
    {4'b0111, 4'b1100, 2'd3}, {4'b1111, 4'b0011, 2'd2}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Starts with the registered accumulate control low; ends after the dump edge.
  task automatic run_sum(input logic [15:0] r, input logic [15:0] i, input int n,
                         input logic [19:0] er, input logic [19:0] ei);
    logic [19:0] prev;
    re_in = r; im_in = i; acc_ctl = 1'b1;
    cyc();
    prev = hold_re;
    for (int k = 0; k < n - 2; k++) cyc();
    chk("R3 hold frozen while accumulating", 32'(hold_re), 32'(prev));
    acc_ctl = 1'b0;
    cyc();
    chk("R4 dump waits one clock", 32'(hold_re), 32'(prev));
    cyc();
    chk("R2 real total", 32'(hold_re), 32'(er));
    chk("R2 imag total", 32'(hold_im), 32'(ei));
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1 growth in reset", 32'(growth), 0);
    rst_n = 1'b1;
    cyc();
    chk("R1 growth after reset", 32'(growth), 0);
    chk("R1 hold_re after reset", 32'(hold_re), 0);
    chk("R1 hold_im after reset", 32'(hold_im), 0);

    for (int v = 0; v < 12; v++) begin
      mul_re_fld = VEC[v][9:6];
      mul_im_fld = VEC[v][5:2];
      cyc();
      chk("R5 window code", 32'(growth), 32'(VEC[v][1:0]));
    end
    mul_re_fld = '0; mul_im_fld = '0;
    cyc();

    run_sum(16'h0300, 16'hFF00, 4, 20'h00C00, 20'hFFC00);
    run_sum(16'h7FFF, 16'h0000, 33, 20'h07FDF, 20'h00000);

    run_sum(16'h4000, 16'h0000, 4, 20'h10000, 20'h00000);
    re_in = '0; im_in = '0;
    cyc();
    chk("R7 aux real growth registered", 32'(growth), 2);
    cyc();
    chk("R7 aux growth drops", 32'(growth), 0);

    run_sum(16'h0000, 16'h8000, 3, 20'h00000, 20'hE8000);
    re_in = '0; im_in = '0; mul_re_fld = 4'b0001;
    cyc();
    chk("R6 aux imag wins max", 32'(growth), 2);
    mul_re_fld = 4'b0100;
    cyc();
    chk("R6 multiplier wins max", 32'(growth), 3);
    mul_re_fld = '0;
    repeat (3) cyc();

    mul_re_fld = 4'b0100;
    cyc();
    chk("R7 track before peak", 32'(growth), 3);
    peak_ctl = 1'b1; mul_re_fld = 4'b0010;
    cyc();
    chk("R4 peak not yet active", 32'(growth), 2);
    mul_re_fld = 4'b0000;
    cyc();
    chk("R10 value at enable kept", 32'(growth), 2);
    mul_re_fld = 4'b0001;
    cyc();
    chk("R8 no drop in peak", 32'(growth), 2);
    mul_re_fld = 4'b0100;
    cyc();
    chk("R8 peak rises", 32'(growth), 3);
    peak_ctl = 1'b0; mul_re_fld = 4'b0000;
    cyc();
    chk("R4 peak still held one clock", 32'(growth), 3);
    cyc();
    chk("R9 tracking resumes", 32'(growth), 0);

    peak_ctl = 1'b1; mul_re_fld = 4'b1011;
    repeat (2) cyc();
    chk("R8 peak set", 32'(growth), 3);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears peak", 32'(growth), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule